// File: doc/BRIEF.md
# Shift-Add Sequential Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit numbers over several clock cycles, using one WIDTH-bit adder. Both operands come in on one shared data bus. A strobe stores the bus value as the multiplicand, and a second strobe stores it as the multiplier. A start pulse then begins the multiply.

Each iteration takes two cycles. In the first cycle, the multiplicand is added into the upper half of the partial product if the lowest multiplier bit is set. The adder's carry goes into a one-bit carry register. In the second cycle, the carry, the upper half and the lower half shift right together as one chain. After WIDTH iterations the full 2·WIDTH-bit product sits on the product output and `busy` falls.

The operand load pins and the start pin are plain control pins with no handshake. The block only acts on them while it is idle. A caller waits for `busy` to fall before it reads the product or supplies new operands.

Top module: `shiftadd_mult`

## Requirements
- R1: While idle, a high `ld_mcand` stores `in_bus` as the multiplicand and a high `ld_mplier` stores `in_bus` as the multiplier, on the next rising edge.
- R2: While `busy` is high, `ld_mcand` and `ld_mplier` are ignored, and the product that is running is not disturbed by them.
- R3: When `busy` falls, `product` equals the unsigned product multiplicand × multiplier on all 2·WIDTH bits. This includes the all-ones operand case, where the adder carries out.
- R4: A `go` pulse sampled while idle raises `busy` on that edge. `busy` then stays high for exactly 2·WIDTH cycles.
- R5: The controller uses the state codes idle=00, check=01 and shift=10. The sequence is idle → check on `go`, check → shift always, and shift → check until the last iteration, then shift → idle. A `go` that arrives while busy has no effect.
- R6: The iteration counter is loaded with WIDTH-1 at start and decrements once in each shift cycle. The last iteration is the shift cycle in which the counter is zero, so exactly WIDTH iterations run.
- R7: The synchronous reset `rst` (active high) forces the idle state and clears all data registers, so `busy`=0 and `product`=0 on the edge after reset, even in the middle of an operation.
- R8: The multiplicand is kept after a product completes. Loading only a new multiplier and pulsing `go` multiplies it by the previous multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bus | input | WIDTH | Shared operand bus |
| ld_mcand | input | 1 | Store `in_bus` as the multiplicand (idle only) |
| ld_mplier | input | 1 | Store `in_bus` as the multiplier (idle only) |
| go | input | 1 | Start a multiply (idle only) |
| busy | output | 1 | High whenever the controller is not idle |
| product | output | 2·WIDTH | Upper and lower partial-product registers, concatenated |

## Verification
The in-line assertions check these behaviours on every cycle:
- each step of the state sequence;
- that the counter loads WIDTH-1 at start and decrements by one in each non-final shift cycle;
- that every shift moves the carry into the top of the upper half and the upper half's low bit into the top of the lower half, and clears the carry;
- that the multiplicand never changes while the block is busy;
- that reset drops `busy`.

Other behaviours only the directed scenarios can show. These are the arithmetic result over many operand pairs, the exact length of the busy window, that load and start strobes are ignored during an operation, and that the multiplicand is kept from one product to the next.

// File: rtl/shiftadd_mult_pkg.sv
package shiftadd_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_CHECK = 2'b01,
    ST_SHIFT = 2'b10
  } ctl_state_t;
endpackage

// File: rtl/sam_controller.sv
module sam_controller
  import shiftadd_mult_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic last_iter,
  output logic in_idle,
  output logic in_check,
  output logic in_shift,
  output logic start
);
  logic [1:0] m_q;
  logic       d_m0, d_m1;

  // state decode
  assign in_idle  = (m_q == ST_IDLE);
  assign in_check = (m_q == ST_CHECK);
  assign in_shift = (m_q == ST_SHIFT);
  assign start    = in_idle & go;

  // next-state equations on the two encoded flip-flops
  assign d_m0 = start | (in_shift & ~last_iter);
  assign d_m1 = in_check;

  always_ff @(posedge clk) begin
    if (rst) m_q <= ST_IDLE;
    else     m_q <= {d_m1, d_m0};
  end

  assert_idle_go_R5: assert property (@(posedge clk) disable iff (rst)
    (in_idle && go) |=> (m_q == ST_CHECK));
  assert_check_to_shift_R5: assert property (@(posedge clk) disable iff (rst)
    in_check |=> (m_q == ST_SHIFT));
  assert_shift_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (in_shift && last_iter) |=> (m_q == ST_IDLE));
  assert_shift_loop_R5: assert property (@(posedge clk) disable iff (rst)
    (in_shift && !last_iter) |=> (m_q == ST_CHECK));
endmodule

// File: rtl/sam_iter_counter.sv
module sam_iter_counter #(
  parameter int WIDTH = 8,
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic step,
  output logic zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (start) cnt_q <= CW'(WIDTH - 1);
    else if (step)  cnt_q <= cnt_q - CW'(1);
  end

  assign zero = (cnt_q == '0);

  assert_count_init_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == CW'(WIDTH - 1)));
  assert_count_dec_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !zero && !start) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   in_bus,
  input  logic               ld_mcand,
  input  logic               ld_mplier,
  input  logic               in_idle,
  input  logic               start,
  input  logic               in_check,
  input  logic               in_shift,
  output logic [2*WIDTH-1:0] product
);
  logic [WIDTH-1:0] b_q, a_q, q_q;
  logic             c_q;
  logic [WIDTH:0]   sum;
  logic             add_en;

  assign sum    = {1'b0, a_q} + {1'b0, b_q};
  assign add_en = in_check & q_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= '0;
      a_q <= '0;
      q_q <= '0;
      c_q <= 1'b0;
    end else begin
      if (in_idle && ld_mcand) b_q <= in_bus;
      if (in_idle && ld_mplier) q_q <= in_bus;
      if (start) begin
        a_q <= '0;
        c_q <= 1'b0;
      end else if (add_en) begin
        a_q <= sum[WIDTH-1:0];
        c_q <= sum[WIDTH];
      end else if (in_shift) begin
        a_q <= {c_q, a_q[WIDTH-1:1]};
        q_q <= {a_q[0], q_q[WIDTH-1:1]};
        c_q <= 1'b0;
      end
    end
  end

  assign product = {a_q, q_q};

  assert_shift_chain_R3: assert property (@(posedge clk) disable iff (rst)
    in_shift |=> (a_q[WIDTH-1] == $past(c_q)) && (q_q[WIDTH-1] == $past(a_q[0])) && !c_q);
  assert_mcand_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_idle |=> $stable(b_q));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   in_bus,
  input  logic               ld_mcand,
  input  logic               ld_mplier,
  input  logic               go,
  output logic               busy,
  output logic [2*WIDTH-1:0] product
);
  logic in_idle, in_check, in_shift, start, last_iter;

  sam_controller u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .last_iter(last_iter),
    .in_idle  (in_idle),
    .in_check (in_check),
    .in_shift (in_shift),
    .start    (start)
  );

  sam_iter_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .step (in_shift),
    .zero (last_iter)
  );

  sam_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .in_bus   (in_bus),
    .ld_mcand (ld_mcand),
    .ld_mplier(ld_mplier),
    .in_idle  (in_idle),
    .start    (start),
    .in_check (in_check),
    .in_shift (in_shift),
    .product  (product)
  );

  assign busy = ~in_idle;

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> (!busy && product == '0));
endmodule

// File: tb/tb_shiftadd_mult.sv
module tb_shiftadd_mult;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] in_bus = '0;
  logic ld_mcand = 1'b0, ld_mplier = 1'b0, go = 1'b0;
  logic busy;
  logic [2*W-1:0] product;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  shiftadd_mult #(.WIDTH(W)) dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] v, input bit mc, input bit mp);
    @(negedge clk);
    in_bus = v; ld_mcand = mc; ld_mplier = mp;
    @(negedge clk);
    ld_mcand = 1'b0; ld_mplier = 1'b0;
  endtask

  // start, watch busy for exactly 2W cycles, then check product
  task automatic run_and_check(input logic [2*W-1:0] exp, input string tag,
                               input bit poke_busy);
    @(negedge clk); go = 1'b1;
    @(posedge clk);
    @(negedge clk); go = 1'b0;
    for (int k = 0; k < 2*W; k++) begin
      if (k > 0) @(negedge clk);
      check("R4 busy window", busy, 1);
      if (poke_busy && k == 3) begin
        in_bus = 8'h5A; ld_mcand = 1'b1; ld_mplier = 1'b1; go = 1'b1;  // R2/R5 ignored
      end else begin
        ld_mcand = 1'b0; ld_mplier = 1'b0; go = 1'b0;
      end
    end
    @(negedge clk);
    check("R4 busy drops after 2W cycles", busy, 0);
    check({tag, " product"}, product, exp);
  endtask

  task automatic t_reset_state();
    check("R7 reset busy", busy, 0);
    check("R7 reset product", product, 0);
  endtask

  task automatic t_products();
    logic [W-1:0] as [7] = '{8'd0, 8'd77, 8'd1, 8'd255, 8'd13, 8'd128, 8'd200};
    logic [W-1:0] bs [7] = '{8'd77, 8'd0, 8'd1, 8'd255, 8'd11, 8'd2, 8'd173};
    for (int i = 0; i < 7; i++) begin
      load(as[i], 1, 0);
      load(bs[i], 0, 1);
      run_and_check((2*W)'(as[i]) * (2*W)'(bs[i]), "R1 R3 R5 R6", 0);
    end
  endtask

  task automatic t_ignore_while_busy();
    load(8'd37, 1, 0);
    load(8'd19, 0, 1);
    run_and_check(16'd703, "R2 R5 strobes ignored while busy", 1);
  endtask

  task automatic t_keep_mcand();
    load(8'd6, 0, 1);  // multiplicand 37 kept
    run_and_check(16'd222, "R8 multiplicand kept", 0);
  endtask

  task automatic t_reset_mid();
    load(8'd99, 1, 0);
    load(8'd99, 0, 1);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 busy before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-op reset busy", busy, 0);
    check("R7 mid-op reset product", product, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_products();
    t_ignore_while_busy();
    t_keep_mcand();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule